// File: doc/BRIEF.md
# Multi-Ratio Clock Divider with Group Phase Select

This block is the synchronous divide stage of a clock-distribution chip. One fast clock comes in and three groups of clock outputs go out: a two-line group at half the fast rate, a four-line group at a quarter and a five-line group at an eighth. Every line of a group carries the same waveform. Each output is high for exactly half of its period, whatever the duty cycle of the fast clock.

The eighth-rate group (group A) can be moved by whole fast-clock periods against the other two groups. A two-bit select chooses one cycle early, aligned, one cycle late or two cycles late. A new select value takes effect only at a rising edge of group A.

The fast clock is normally the on-chip oscillator clock. With `test_mode` set, the reference clock drives the same divider instead. A glitch-free two-sided handover performs the swap. Once the new clock runs, the divide counter restarts so that all groups line up again.

Top module: `pdiv_top`

## Requirements
- R1: `grp_c` has a period of 2 fast-clock cycles and is high for 1 of them.
- R2: `grp_b` has a period of 4 fast-clock cycles and is high for 2 of them.
- R3: While the select is steady, `grp_a` has a period of 8 fast-clock cycles and is high for 4 of them.
- R4: All lines within one group carry the same value in every cycle.
- R5: Every rising edge of `grp_b` falls in the same fast cycle as a rising edge of `grp_c`, for any select value.
- R6: The select value {shift_sel[1],shift_sel[0]} sets the lag, in fast cycles, from the latest `grp_b` rising edge to the `grp_a` rising edge. The code 2'b00 gives a lag of 3, which places `grp_a` one cycle ahead of the aligned point. The code 2'b01 gives 0 (aligned), 2'b10 gives 1 (one cycle late) and 2'b11 gives 2 (two cycles late).
- R7: `rst` is synchronous and active high. While it is asserted, all outputs are low. With select 2'b01, all three groups rise together on the first fast-clock edge after release.
- R8: A select change is applied at the next `grp_a` rising edge. That edge still uses the old shift, and the following rising edge uses the new one.
- R9: With `test_mode` = 0 the divider counts `osc_clk` cycles. With `test_mode` = 1 it counts `ref_clk` cycles, and R1 to R6 hold in those cycles.
- R10: The source handover never enables both clocks at once. After a handover the counter restarts, so R5 and R6 hold on the new clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock, the fast clock in normal mode |
| ref_clk | input | 1 | Reference clock, the fast clock in test mode |
| rst | input | 1 | Active-high reset; synchronous for the divider, immediate for the source handover |
| test_mode | input | 1 | 1 selects ref_clk as the fast clock |
| shift_sel | input | 2 | Group A shift code (see R6) |
| grp_a | output | N_A (5) | Fast clock divided by 8, shiftable |
| grp_b | output | N_B (4) | Fast clock divided by 4 |
| grp_c | output | N_C (2) | Fast clock divided by 2 |

## Verification
The assertions take `shift_sel` and `test_mode` to be quasi-static: they change away from any active edge of the running fast clock, and `test_mode` changes only while both source clocks are toggling. They also take `rst` to be held for several oscillator cycles. The bench therefore changes the select after a sample taken at a falling edge of the clock in use. It changes the mode only after a sample taken at an oscillator falling edge, a point that never coincides with a reference-clock rising edge. It keeps both clocks running for the whole run.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

   // Group A shift codes, bit 0 is the low select line
   typedef enum logic [1:0] {
      SH_LEAD1 = 2'b00,
      SH_ZERO  = 2'b01,
      SH_LAG1  = 2'b10,
      SH_LAG2  = 2'b11
   } shift_e;

   // Signed offset added to the group A phase: positive moves edges earlier
   function automatic int shift_cycles(input shift_e code);
      case (code)
         SH_LEAD1: return 1;
         SH_ZERO:  return 0;
         SH_LAG1:  return -1;
         default:  return -2;
      endcase
   endfunction

endpackage

// File: rtl/pdiv_clk_switch.sv
module pdiv_clk_switch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_norm,
   input  logic clk_alt,
   input  logic rst,
   input  logic want_alt,
   output logic clk_out,
   output logic norm_on,
   output logic alt_on
);
   localparam int PW = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("pdiv_clk_switch: SYNC_STAGES must be at least 2");
   end

   logic [1:0] side_clk;
   logic [1:0] side_en;
   logic [1:0] side_want;

   assign side_clk  = {clk_alt, clk_norm};
   // each side may start only once the other side has dropped out
   assign side_want = {want_alt & ~side_en[0], ~want_alt & ~side_en[1]};

   for (genvar s = 0; s < 2; s++) begin : g_side
      localparam logic RST_VAL = (s == 0);
      logic [PW-1:0] pipe;
      logic [PW:0]   pipe_nx;

      assign pipe_nx = {pipe, side_want[s]};

      always_ff @(posedge side_clk[s] or posedge rst) begin
         if (rst) pipe <= {PW{RST_VAL}};
         else     pipe <= pipe_nx[PW-1:0];
      end

      // enable changes only while this clock is low
      always_ff @(negedge side_clk[s] or posedge rst) begin
         if (rst) side_en[s] <= RST_VAL;
         else     side_en[s] <= pipe[PW-1];
      end
   end

   assign clk_out = (clk_norm & side_en[0]) | (clk_alt & side_en[1]);
   assign norm_on = side_en[0];
   assign alt_on  = side_en[1];
endmodule

// File: rtl/pdiv_shift_ctl.sv
module pdiv_shift_ctl
   import pdiv_pkg::*;
#(
   parameter int DIV_BITS = 3
) (
   input  logic                fclk,
   input  logic                rst,
   input  logic                a_boundary,
   input  logic [1:0]          shift_sel,
   output logic [DIV_BITS-1:0] offset
);
   logic [DIV_BITS-1:0] offset_new;

   assign offset_new = DIV_BITS'(shift_cycles(shift_e'(shift_sel)));

   // new shift is taken only where group A rises
   always_ff @(posedge fclk) begin
      if (rst || a_boundary) offset <= offset_new;
   end
endmodule

// File: rtl/pdiv_core.sv
module pdiv_core #(
   parameter int DIV_BITS = 3
) (
   input  logic                fclk,
   input  logic                rst,
   input  logic                src_alt,
   input  logic [DIV_BITS-1:0] offset,
   output logic                a_bit,
   output logic                b_bit,
   output logic                c_bit,
   output logic                a_boundary,
   output logic                restart
);
   localparam int MSB = DIV_BITS - 1;

   if (DIV_BITS < 3) begin : g_bad_bits
      $error("pdiv_core: DIV_BITS must be at least 3");
   end

   logic [MSB:0] cnt;
   logic [MSB:0] cnt_nx;
   logic [MSB:0] ph_nx;
   logic         src_seen;

   assign cnt_nx     = cnt + 1'b1;
   assign ph_nx      = cnt_nx + offset;
   assign restart    = src_seen ^ src_alt;
   assign a_boundary = ~rst & ~restart & (ph_nx == '0);

   always_ff @(posedge fclk) begin
      if (rst || restart) begin
         cnt      <= '1;
         a_bit    <= 1'b0;
         b_bit    <= 1'b0;
         c_bit    <= 1'b0;
         src_seen <= src_alt;
      end else begin
         cnt   <= cnt_nx;
         c_bit <= ~cnt_nx[0];
         b_bit <= ~cnt_nx[1];
         a_bit <= ~ph_nx[MSB];
      end
   end
endmodule

// File: rtl/pdiv_fanout.sv
module pdiv_fanout #(
   parameter int WIDTH = 1
) (
   input  logic             src,
   output logic [WIDTH-1:0] dst
);
   if (WIDTH < 1) begin : g_bad_width
      $error("pdiv_fanout: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_line
      assign dst[i] = src;
   end
endmodule

// File: rtl/pdiv_top.sv
module pdiv_top #(
   parameter int N_A         = 5,
   parameter int N_B         = 4,
   parameter int N_C         = 2,
   parameter int DIV_BITS    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic           osc_clk,
   input  logic           ref_clk,
   input  logic           rst,
   input  logic           test_mode,
   input  logic [1:0]     shift_sel,
   output logic [N_A-1:0] grp_a,
   output logic [N_B-1:0] grp_b,
   output logic [N_C-1:0] grp_c
);
   logic                fclk;
   logic                osc_en;
   logic                ref_en;
   logic                restart;
   logic                a_boundary;
   logic                a_bit;
   logic                b_bit;
   logic                c_bit;
   logic [DIV_BITS-1:0] off_q;

   pdiv_clk_switch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
      .clk_norm (osc_clk),
      .clk_alt  (ref_clk),
      .rst      (rst),
      .want_alt (test_mode),
      .clk_out  (fclk),
      .norm_on  (osc_en),
      .alt_on   (ref_en)
   );

   pdiv_shift_ctl #(.DIV_BITS(DIV_BITS)) u_shift (
      .fclk       (fclk),
      .rst        (rst),
      .a_boundary (a_boundary),
      .shift_sel  (shift_sel),
      .offset     (off_q)
   );

   pdiv_core #(.DIV_BITS(DIV_BITS)) u_core (
      .fclk       (fclk),
      .rst        (rst),
      .src_alt    (ref_en),
      .offset     (off_q),
      .a_bit      (a_bit),
      .b_bit      (b_bit),
      .c_bit      (c_bit),
      .a_boundary (a_boundary),
      .restart    (restart)
   );

   pdiv_fanout #(.WIDTH(N_A)) u_fan_a (.src(a_bit), .dst(grp_a));
   pdiv_fanout #(.WIDTH(N_B)) u_fan_b (.src(b_bit), .dst(grp_b));
   pdiv_fanout #(.WIDTH(N_C)) u_fan_c (.src(c_bit), .dst(grp_c));
endmodule

// File: rtl/pdiv_chk.sv
module pdiv_chk #(
   parameter int N_A      = 5,
   parameter int N_B      = 4,
   parameter int N_C      = 2,
   parameter int DIV_BITS = 3
) (
   input logic                fclk,
   input logic                osc_clk,
   input logic                rst,
   input logic                restart,
   input logic                osc_en,
   input logic                ref_en,
   input logic [N_A-1:0]      grp_a,
   input logic [N_B-1:0]      grp_b,
   input logic [N_C-1:0]      grp_c,
   input logic [DIV_BITS-1:0] off_q
);
   // R1
   c_single_high_chk: assert property (@(posedge fclk) disable iff (rst)
      grp_c[0] |=> !grp_c[0]);

   // R2
   b_hold_chk: assert property (@(posedge fclk) disable iff (rst || restart)
      $rose(grp_b[0]) |=> grp_b[0]);

   // R3
   a_hold_chk: assert property (@(posedge fclk) disable iff (rst || restart)
      ($rose(grp_a[0]) && $stable(off_q)) |=> grp_a[0]);

   // R4
   group_uniform_chk: assert property (@(posedge fclk) disable iff (rst)
      (grp_a == '0 || grp_a == '1) && (grp_b == '0 || grp_b == '1) &&
      (grp_c == '0 || grp_c == '1));

   // R5
   bc_align_chk: assert property (@(posedge fclk) disable iff (rst)
      $rose(grp_b[0]) |-> $rose(grp_c[0]));

   // R8
   shift_at_boundary_chk: assert property (@(posedge fclk) disable iff (rst)
      !$stable(off_q) |-> $rose(grp_a[0]));

   // R10
   one_source_chk: assert property (@(posedge osc_clk) disable iff (rst)
      !(osc_en && ref_en));
endmodule

bind pdiv_top pdiv_chk #(
   .N_A(N_A), .N_B(N_B), .N_C(N_C), .DIV_BITS(DIV_BITS)
) u_chk (
   .fclk    (fclk),
   .osc_clk (osc_clk),
   .rst     (rst),
   .restart (restart),
   .osc_en  (osc_en),
   .ref_en  (ref_en),
   .grp_a   (grp_a),
   .grp_b   (grp_b),
   .grp_c   (grp_c),
   .off_q   (off_q)
);

// File: tb/pdiv_top_bench.sv
module pdiv_top_bench;
   typedef struct packed {
      logic       mode;
      logic [1:0] sel;
      logic [2:0] lag;
   } vec_t;

   // R6 lag table for both sources (R9, R10)
   localparam vec_t VECS [8] = '{
      '{1'b0, 2'b00, 3'd3}, '{1'b0, 2'b01, 3'd0},
      '{1'b0, 2'b10, 3'd1}, '{1'b0, 2'b11, 3'd2},
      '{1'b1, 2'b00, 3'd3}, '{1'b1, 2'b01, 3'd0},
      '{1'b1, 2'b10, 3'd1}, '{1'b1, 2'b11, 3'd2}
   };

   logic       osc_clk = 1'b0;
   logic       ref_clk = 1'b0;
   logic       rst = 1'b1;
   logic       test_mode = 1'b0;
   logic [1:0] shift_sel = 2'b01;
   logic [4:0] grp_a;
   logic [3:0] grp_b;
   logic [1:0] grp_c;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   always #10 osc_clk = ~osc_clk;
   always #7  ref_clk = ~ref_clk;

   pdiv_top u_pdiv_top (
      .osc_clk   (osc_clk),
      .ref_clk   (ref_clk),
      .rst       (rst),
      .test_mode (test_mode),
      .shift_sel (shift_sel),
      .grp_a     (grp_a),
      .grp_b     (grp_b),
      .grp_c     (grp_c)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input bit use_ref);
      if (use_ref) @(negedge ref_clk);
      else         @(negedge osc_clk);
   endtask

   task automatic measure(input bit use_ref, input int exp_lag, input string lbl);
      int    exp_per [3] = '{8, 4, 2};
      int    exp_hi  [3] = '{4, 2, 1};
      string rq      [3] = '{"R3", "R2", "R1"};
      int    last_r  [3] = '{-1, -1, -1};
      int    bad_per [3] = '{0, 0, 0};
      int    bad_hi  [3] = '{0, 0, 0};
      int    bad_lag = -1;
      int    a_rises = 0;
      bit    bad_uni = 1'b0;
      bit    bad_bc = 1'b0;
      logic [2:0] cur;
      logic [2:0] prv;
      prv = 3'b000;
      for (int i = 0; i < 48; i++) begin
         tick(use_ref);
         cur = {grp_c[0], grp_b[0], grp_a[0]};
         if (!((grp_a == '0 || grp_a == '1) && (grp_b == '0 || grp_b == '1) &&
               (grp_c == '0 || grp_c == '1))) bad_uni = 1'b1;
         if (i > 0) begin
            for (int g = 0; g < 3; g++) begin
               if (cur[g] && !prv[g]) begin
                  if (last_r[g] >= 0 && (i - last_r[g]) != exp_per[g] && bad_per[g] == 0)
                     bad_per[g] = i - last_r[g];
                  last_r[g] = i;
               end
               if (!cur[g] && prv[g] && last_r[g] >= 0 &&
                   (i - last_r[g]) != exp_hi[g] && bad_hi[g] == 0)
                  bad_hi[g] = i - last_r[g];
            end
            if (cur[1] && !prv[1] && !(cur[2] && !prv[2])) bad_bc = 1'b1;
            if (cur[0] && !prv[0] && last_r[1] >= 0) begin
               a_rises++;
               if ((i - last_r[1]) != exp_lag && bad_lag < 0) bad_lag = i - last_r[1];
            end
         end
         prv = cur;
      end
      for (int g = 0; g < 3; g++) begin
         chk(bad_per[g] == 0, {lbl, " ", rq[g], " period"},
             (bad_per[g] == 0) ? exp_per[g] : bad_per[g], exp_per[g]);
         chk(bad_hi[g] == 0, {lbl, " ", rq[g], " high width"},
             (bad_hi[g] == 0) ? exp_hi[g] : bad_hi[g], exp_hi[g]);
      end
      chk(!bad_uni, {lbl, " R4 group lines equal"}, int'(bad_uni), 0);
      chk(!bad_bc, {lbl, " R5 B/C rise together"}, int'(bad_bc), 0);
      chk(bad_lag < 0 && a_rises > 0, {lbl, " R6 A lag after B"},
          (bad_lag < 0) ? ((a_rises > 0) ? exp_lag : -1) : bad_lag, exp_lag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge osc_clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      // R7 reset state and first edge
      repeat (4) tick(1'b0);
      chk(grp_a == '0 && grp_b == '0 && grp_c == '0, "R7 outputs low in reset",
          int'({grp_a, grp_b, grp_c}), 0);
      rst = 1'b0;
      tick(1'b0);
      chk(grp_a == '1 && grp_b == '1 && grp_c == '1, "R7 all groups rise on first edge",
          int'({grp_a, grp_b, grp_c}), 11'h7ff);
      tick(1'b0);
      chk(grp_a == '1 && grp_b == '1 && grp_c == '0, "R7 second cycle pattern",
          int'({grp_a, grp_b, grp_c}), 11'h7fc);

      // table walk: R6 in both modes, R9 and R10 on the reference clock
      for (int v = 0; v < 8; v++) begin
         if (VECS[v].mode != test_mode) begin
            tick(1'b0);
            test_mode = VECS[v].mode;
         end
         shift_sel = VECS[v].sel;
         repeat (30) tick(test_mode);
         measure(test_mode, int'(VECS[v].lag),
                 VECS[v].mode ? "R9/R10 ref" : "R9 osc");
      end

      // back to the oscillator
      tick(1'b0);
      test_mode = 1'b0;
      shift_sel = 2'b01;
      repeat (30) tick(1'b0);

      // R8 select change applies only from the next A boundary
      begin
         logic pa, pb;
         int   lastb = -1;
         int   rise_at = -1;
         int   lag1 = -1;
         int   lag2 = -1;
         bit   changed = 1'b0;
         pa = grp_a[0];
         pb = grp_b[0];
         for (int i = 1; i < 60; i++) begin
            tick(1'b0);
            if (grp_b[0] && !pb) lastb = i;
            if (grp_a[0] && !pa) begin
               if (rise_at < 0) rise_at = i;
               else if (changed && lag1 < 0) lag1 = i - lastb;
               else if (changed && lag2 < 0) lag2 = i - lastb;
            end
            pa = grp_a[0];
            pb = grp_b[0];
            if (!changed && rise_at >= 0 && i == rise_at + 2) begin
               shift_sel = 2'b11;
               changed = 1'b1;
            end
         end
         chk(lag1 == 0, "R8 old shift kept up to boundary", lag1, 0);
         chk(lag2 == 2, "R8 new shift after boundary", lag2, 2);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule